// File: doc/BRIEF.md
# Sleep and Wake Controller

This block is the always-on, low-rate part of a radio baseband chip. It puts the high-rate logic to sleep when the host microcontroller asks for it, and it wakes that logic again. While asleep it raises a hold signal that parks the high-rate pins in high impedance and blocks their inputs. It also drops a DC power-enable output that feeds external circuits.

Three events end a sleep period. The first is a timer that expires after half the cycle of a binary divider. The second is an edge on the intercom input. The third is an edge on the flip-switch input. For each input, the host chooses whether the rising or the falling edge counts. The cause of the wake is kept in a small reason register until the host reads it. While awake, the same edges set activity flags that the host can poll.

The host requests sleep through a two-step rule. It first writes the operate bit. A later standby write is the only thing that starts sleep. The sleep request and the sleep state cross between the host side and the slow side through flop synchronisers. The slow side runs from the shared clock and advances only on a slow oscillator tick enable.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: Once asleep, the block wakes on its own on the 2^(TIMER_BITS-1)-th slow tick after the tick on which it entered sleep, and it sets reason bit 0 (timer).
- R2: While asleep, a qualifying edge on `intercom_in` wakes the block on the next slow tick and sets reason bit 1. The edge qualifies if it is rising when `icom_rise`=1, or falling when `icom_rise`=0. Each slow tick compares the pin with its value at the previous tick.
- R3: While asleep, a qualifying edge on `flipsw_in` wakes the block and sets reason bit 2. Its edge sense comes from `flip_rise` and is independent of the intercom setting.
- R4: When several wake causes occur on the same slow tick, all of their reason bits are set. Reason bits are sticky. A host read (`stat_rd`) clears them, but a bit set in the same cycle as the read survives.
- R5: A write with `ctl_standby`=1 starts sleep only if an earlier write has left the operate bit at 1. Otherwise the operate bit takes `ctl_operate`. An accepted standby clears the operate bit.
- R6: `dc_pwr_on` is low exactly while the slow side is asleep. `io_hold` follows the slow sleep state delayed by SYNC_STAGES+1 clocks.
- R7: While awake, qualifying edges set activity bits (bit 0 intercom, bit 1 flip-switch). These bits are sticky until `stat_rd`, and they are not set while asleep.
- R8: While `io_hold` is high, bus writes and reads are ignored. The operate bit, the reason bits and the activity bits stay unchanged by them.
- R9: The sleep timer restarts from zero on every sleep entry.
- R10: The slow side enters sleep on the first slow tick at which the synchronised request is newly high. The host request drops once the synchronised sleep state is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-clock enable from the slow oscillator |
| intercom_in | input | 1 | Intercom wake pin |
| flipsw_in | input | 1 | Flip-switch wake pin |
| icom_rise | input | 1 | Intercom edge sense, 1 rising, 0 falling |
| flip_rise | input | 1 | Flip-switch edge sense, 1 rising, 0 falling |
| ctl_we | input | 1 | Control register write strobe |
| ctl_operate | input | 1 | Operate bit write data |
| ctl_standby | input | 1 | Standby command write data |
| stat_rd | input | 1 | Status read strobe, clears reason and activity bits |
| wake_reason | output | 3 | Wake cause: bit0 timer, bit1 intercom, bit2 flip-switch |
| activity | output | 2 | Awake edge flags: bit0 intercom, bit1 flip-switch |
| io_hold | output | 1 | High-rate I/O park and input block |
| dc_pwr_on | output | 1 | External DC power enable, low while asleep |

## Verification
The bench builds the block with TIMER_BITS=4, so timer expiry comes after 8 slow ticks, and with SYNC_STAGES=2. It raises a slow tick every fifth clock. With these values, a full timer period, a timer restart after a short intercom-triggered sleep, and coincident pin edges on one tick all fit in a few hundred clocks. The synchroniser lag also lands at different phases of the tick, so the entry and exit handshakes are exercised at several alignments.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int REASON_W  = 3;
  localparam int RSN_TIMER = 0;
  localparam int RSN_ICOM  = 1;
  localparam int RSN_FLIP  = 2;
  localparam int ACT_W     = 2;
  localparam int ACT_ICOM  = 0;
  localparam int ACT_FLIP  = 1;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 1) begin : g_one
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= 1'b0;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/swc_edge.sv
module swc_edge (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin,
  input  logic rise_sel,
  output logic evt
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst)       prev <= 1'b0;
    else if (tick) prev <= pin;
  end

  always_comb evt = rise_sel ? (pin & ~prev) : (~pin & prev);
endmodule

// File: rtl/swc_host.sv
module swc_host (
  input  logic clk,
  input  logic rst,
  input  logic ctl_we,
  input  logic ctl_operate,
  input  logic ctl_standby,
  input  logic stat_rd,
  input  logic asleep_sync,
  output logic sleep_req,
  output logic io_hold,
  output logic rd_ok
);
  logic op_q, wr_ok, accept;

  always_comb begin
    wr_ok  = ctl_we && !io_hold;
    accept = wr_ok && ctl_standby && op_q && !sleep_req && !asleep_sync;
    rd_ok  = stat_rd && !io_hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= 1'b0;
      sleep_req <= 1'b0;
      io_hold   <= 1'b0;
    end else begin
      io_hold <= asleep_sync;
      if (asleep_sync)  sleep_req <= 1'b0;
      else if (accept)  sleep_req <= 1'b1;
      if (accept)       op_q <= 1'b0;
      else if (wr_ok)   op_q <= ctl_operate;
    end
  end

  // R5: a request only rises when the operate bit was already set
  assert_standby_gate_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_req) |-> $past(op_q));

  // R8: bus writes leave the operate bit alone while held
  assert_hold_blocks_write_R8: assert property (@(posedge clk) disable iff (rst)
    io_hold |=> $stable(op_q));
endmodule

// File: rtl/swc_slow.sv
module swc_slow
  import swc_pkg::*;
#(
  parameter int TIMER_BITS = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                ev_icom,
  input  logic                ev_flip,
  input  logic                req_sync,
  input  logic                rd_clr,
  output logic                asleep,
  output logic [REASON_W-1:0] reason,
  output logic [ACT_W-1:0]    act
);
  localparam int HALF = 1 << (TIMER_BITS - 1);
  localparam logic [TIMER_BITS-1:0] LAST = TIMER_BITS'(HALF - 1);

  logic [TIMER_BITS-1:0] cnt;
  logic                  req_prev, tmo, wake;
  logic [REASON_W-1:0]   rsn_set;
  logic [ACT_W-1:0]      act_set;

  always_comb begin
    tmo     = asleep && (cnt == LAST);
    wake    = tick && asleep && (tmo || ev_icom || ev_flip);
    rsn_set = '0;
    if (wake) begin
      rsn_set[RSN_TIMER] = tmo;
      rsn_set[RSN_ICOM]  = ev_icom;
      rsn_set[RSN_FLIP]  = ev_flip;
    end
    act_set = '0;
    if (tick && !asleep) begin
      act_set[ACT_ICOM] = ev_icom;
      act_set[ACT_FLIP] = ev_flip;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      asleep   <= 1'b0;
      cnt      <= '0;
      req_prev <= 1'b0;
      reason   <= '0;
      act      <= '0;
    end else begin
      reason <= (reason & {REASON_W{~rd_clr}}) | rsn_set;
      act    <= (act & {ACT_W{~rd_clr}}) | act_set;
      if (tick) begin
        req_prev <= req_sync;
        if (asleep) begin
          cnt <= cnt + 1'b1;
          if (wake) asleep <= 1'b0;
        end else if (req_sync && !req_prev) begin
          asleep <= 1'b1;
          cnt    <= '0;
        end
      end
    end
  end

  // R1: the timer never runs past its last count while asleep
  assert_timer_bound_R1: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (cnt <= LAST));

  // R9: every sleep entry starts the timer from zero
  assert_timer_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> (cnt == '0));

  // R4: leaving sleep always leaves a recorded cause
  assert_reason_on_wake_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep) |-> (reason != '0));

  // R7: activity flags do not gain bits while asleep
  assert_act_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (asleep && !rd_clr) |=> $stable(act));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int TIMER_BITS  = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slow_tick,
  input  logic                intercom_in,
  input  logic                flipsw_in,
  input  logic                icom_rise,
  input  logic                flip_rise,
  input  logic                ctl_we,
  input  logic                ctl_operate,
  input  logic                ctl_standby,
  input  logic                stat_rd,
  output logic [REASON_W-1:0] wake_reason,
  output logic [ACT_W-1:0]    activity,
  output logic                io_hold,
  output logic                dc_pwr_on
);
  logic [ACT_W-1:0] pins, sels, evs;
  logic sleep_req, req_s, asleep, asleep_s, rd_ok;

  assign pins[ACT_ICOM] = intercom_in;
  assign pins[ACT_FLIP] = flipsw_in;
  assign sels[ACT_ICOM] = icom_rise;
  assign sels[ACT_FLIP] = flip_rise;

  for (genvar i = 0; i < ACT_W; i++) begin : g_edge
    swc_edge u_edge (
      .clk(clk), .rst(rst), .tick(slow_tick),
      .pin(pins[i]), .rise_sel(sels[i]), .evt(evs[i])
    );
  end

  swc_host u_host (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_operate(ctl_operate),
    .ctl_standby(ctl_standby), .stat_rd(stat_rd), .asleep_sync(asleep_s),
    .sleep_req(sleep_req), .io_hold(io_hold), .rd_ok(rd_ok)
  );

  swc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d(sleep_req), .q(req_s)
  );

  swc_sync #(.STAGES(SYNC_STAGES)) u_slp_sync (
    .clk(clk), .rst(rst), .d(asleep), .q(asleep_s)
  );

  swc_slow #(.TIMER_BITS(TIMER_BITS)) u_slow (
    .clk(clk), .rst(rst), .tick(slow_tick),
    .ev_icom(evs[ACT_ICOM]), .ev_flip(evs[ACT_FLIP]),
    .req_sync(req_s), .rd_clr(rd_ok),
    .asleep(asleep), .reason(wake_reason), .act(activity)
  );

  assign dc_pwr_on = ~asleep;

  // R10: the host request is never left pending while the hold is up
  assert_req_drops_R10: assert property (@(posedge clk) disable iff (rst)
    (io_hold && asleep_s) |-> !sleep_req);
endmodule

// File: tb/sleep_wake_ctrl_test.sv
module sleep_wake_ctrl_test;
  localparam int TB_TIMER = 4;
  localparam int TB_SYNC  = 2;
  localparam int HALF     = 1 << (TB_TIMER - 1);
  localparam int TICK_DIV = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_tick = 1'b0;
  logic intercom_in = 1'b0, flipsw_in = 1'b0;
  logic icom_rise = 1'b1, flip_rise = 1'b1;
  logic ctl_we = 1'b0, ctl_operate = 1'b0, ctl_standby = 1'b0, stat_rd = 1'b0;
  logic [2:0] wake_reason;
  logic [1:0] activity;
  logic io_hold, dc_pwr_on;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sleep_wake_ctrl #(.TIMER_BITS(TB_TIMER), .SYNC_STAGES(TB_SYNC)) uut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick),
    .intercom_in(intercom_in), .flipsw_in(flipsw_in),
    .icom_rise(icom_rise), .flip_rise(flip_rise),
    .ctl_we(ctl_we), .ctl_operate(ctl_operate), .ctl_standby(ctl_standby),
    .stat_rd(stat_rd), .wake_reason(wake_reason), .activity(activity),
    .io_hold(io_hold), .dc_pwr_on(dc_pwr_on)
  );

  always #5 clk = ~clk;

  int tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt  <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    slow_tick <= (tick_cnt == TICK_DIV - 1);
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: queues model the crossing lag in whole clocks
  bit m_asleep, m_req, m_op, m_hold, m_ip, m_fp, m_rqprev;
  int m_ticks;
  bit [2:0] m_reason;
  bit [1:0] m_act;
  bit slp_hist[$];
  bit req_hist[$];

  always @(posedge clk) begin
    if (rst) begin
      m_asleep = 0; m_req = 0; m_op = 0; m_hold = 0; m_ip = 0; m_fp = 0;
      m_rqprev = 0; m_ticks = 0; m_reason = 0; m_act = 0;
      slp_hist = {}; req_hist = {};
      for (int i = 0; i <= TB_SYNC; i++) begin
        slp_hist.push_back(1'b0);
        req_hist.push_back(1'b0);
      end
    end else begin
      bit seen_slp, seen_req, rd_ok, wr_ok, acc, ei, ef, wake, tmo;
      bit [2:0] rset;
      bit [1:0] aset;
      seen_slp = slp_hist.pop_front();
      seen_req = req_hist.pop_front();
      rd_ok = stat_rd && !m_hold;
      wr_ok = ctl_we && !m_hold;
      acc = wr_ok && ctl_standby && m_op && !m_req && !seen_slp;
      ei = icom_rise ? (intercom_in && !m_ip) : (!intercom_in && m_ip);
      ef = flip_rise ? (flipsw_in && !m_fp) : (!flipsw_in && m_fp);
      rset = 0; aset = 0;
      if (slow_tick) begin
        if (m_asleep) begin
          m_ticks++;
          tmo = (m_ticks == HALF);
          wake = tmo || ei || ef;
          if (wake) begin
            rset = {ef, ei, tmo};
            m_asleep = 0;
          end
        end else begin
          aset = {ef, ei};
          if (seen_req && !m_rqprev) begin
            m_asleep = 1;
            m_ticks = 0;
          end
        end
        m_rqprev = seen_req;
        m_ip = intercom_in;
        m_fp = flipsw_in;
      end
      m_reason = (rd_ok ? 3'b000 : m_reason) | rset;
      m_act = (rd_ok ? 2'b00 : m_act) | aset;
      if (acc) m_op = 0;
      else if (wr_ok) m_op = ctl_operate;
      if (seen_slp) m_req = 0;
      else if (acc) m_req = 1;
      m_hold = seen_slp;
      slp_hist.push_back(m_asleep);
      req_hist.push_back(m_req);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4 reason vs model", wake_reason, m_reason);
      check("R7 activity vs model", activity, m_act);
      check("R6 io_hold vs model", io_hold, m_hold);
      check("R6 dc_pwr_on vs model", dc_pwr_on, !m_asleep);
    end
  end

  task automatic wait_ticks(int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic bus_write(bit op, bit sb);
    @(negedge clk);
    ctl_we = 1; ctl_operate = op; ctl_standby = sb;
    @(negedge clk);
    ctl_we = 0; ctl_operate = 0; ctl_standby = 0;
  endtask

  task automatic bus_read();
    @(negedge clk);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
  endtask

  task automatic go_sleep();
    bus_write(1, 0);
    bus_write(0, 1);
    wait_ticks(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R6 reset reason", wake_reason, 0);
    check("R7 reset activity", activity, 0);
    check("R6 reset io_hold", io_hold, 0);
    check("R6 reset dc_pwr_on", dc_pwr_on, 1);

    // R5: standby without prior operate is refused
    bus_write(0, 1);
    wait_ticks(4);
    check("R5 no sleep without operate", dc_pwr_on, 1);

    // R1, R10: two-step entry, then timer wake
    go_sleep();
    check("R10 asleep after standby", dc_pwr_on, 0);
    check("R6 hold while asleep", io_hold, 1);
    wait_ticks(HALF + 1);
    check("R1 timer wake power", dc_pwr_on, 1);
    check("R1 timer reason", wake_reason, 3'b001);
    bus_read();
    check("R4 read clears reason", wake_reason, 0);

    // R2: rising-edge intercom wake
    icom_rise = 1;
    go_sleep();
    wait_ticks(2);
    intercom_in = 1;
    wait_ticks(2);
    check("R2 intercom wake", dc_pwr_on, 1);
    check("R2 intercom reason", wake_reason, 3'b010);
    intercom_in = 0;
    bus_read();

    // R9: timer restarts on re-entry
    go_sleep();
    wait_ticks(5);
    check("R9 still asleep after partial period", dc_pwr_on, 0);
    wait_ticks(4);
    check("R9 timer wake after full period", wake_reason, 3'b001);
    bus_read();

    // R3: falling-edge flip-switch wake
    flip_rise = 0;
    flipsw_in = 1;
    wait_ticks(2);
    go_sleep();
    wait_ticks(2);
    flipsw_in = 0;
    wait_ticks(2);
    check("R3 flip wake", dc_pwr_on, 1);
    check("R3 flip reason", wake_reason, 3'b100);
    check("R7 unsensed edge leaves activity", activity, 0);
    bus_read();

    // R4: two causes on one tick
    flip_rise = 1;
    go_sleep();
    wait_ticks(2);
    intercom_in = 1; flipsw_in = 1;
    wait_ticks(2);
    check("R4 both reasons", wake_reason, 3'b110);
    bus_read();
    check("R4 cleared after read", wake_reason, 0);
    intercom_in = 0; flipsw_in = 0;
    wait_ticks(2);

    // R7: awake activity flags
    intercom_in = 1;
    wait_ticks(2);
    check("R7 intercom activity", activity, 2'b01);
    flipsw_in = 1;
    wait_ticks(2);
    check("R7 both activity", activity, 2'b11);
    bus_read();
    check("R7 read clears activity", activity, 0);
    intercom_in = 0; flipsw_in = 0;
    wait_ticks(2);

    // R8: bus ignored while held
    go_sleep();
    wait_ticks(2);
    intercom_in = 1;
    wait_ticks(2);
    check("R8 setup reason unread", wake_reason, 3'b010);
    intercom_in = 0;
    go_sleep();
    bus_write(1, 0);
    bus_read();
    wait_ticks(HALF + 1);
    check("R8 read while held ignored", wake_reason, 3'b011);
    bus_write(0, 1);
    wait_ticks(4);
    check("R8 operate write while held ignored", dc_pwr_on, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule